// File: doc/BRIEF.md
# Floating-Point Compare Flag Generator

This block compares two scalar IEEE-754 values and writes the result as four condition flags, negative (N), zero (Z), carry (C) and overflow (V). A size code chooses between single and double precision. A zero-compare select replaces the second operand with +0.0. The result is registered. A request is presented on one clock edge and the flags register shows its outcome from that edge onward. Without a request the register holds its value.

In conditional mode the block first tests a 4-bit condition code against the flags supplied on its input. If the condition holds, the comparison is done as usual. If it does not, a 4-bit immediate is loaded into the flags instead. An unsupported size code raises an error output and leaves the flags untouched. Signalling and quiet comparisons share one path and produce identical flags, so the block has no separate input for them.

Top module: `fpcmp_flag_unit`

## Requirements
- R1: While reset is asserted and after its release, `flags_o` is 4'b0000 and `err_o` is 0 until the first request. Flag bit positions: [3]=N, [2]=Z, [1]=C, [0]=V.
- R2: Size code 0 compares the low 32 bits of each operand as single precision and ignores bits [63:32]. Size code 1 compares all 64 bits as double precision. Codes 2 and 3 set `err_o` to 1 and leave `flags_o` at its previous value. Any request with code 0 or 1 clears `err_o`.
- R3: A comparison with a NaN operand produces flags 4'b0011. A NaN has an all-ones exponent and a nonzero fraction. In the zero-compare form only the first operand is tested for NaN.
- R4: An ordered comparison sets Z when the values are equal, C when the first is greater than or equal to the second, and N when the first is less than the second. It always clears V.
- R5: +0.0 and -0.0 compare equal. Infinities order by their sign against all finite values. Finite values order by numeric value.
- R6: When `zero_cmp_i` is 1, the second operand is +0.0 at the selected precision and `opb_i` has no effect.
- R7: When `cond_mode_i` is 1, the condition is tested against `flags_in_i`. Bits [3:1] of the code select the test: 0 Z, 1 C, 2 N, 3 V, 4 C&!Z, 5 N==V, 6 !Z&(N==V), 7 always. Bit [0]=1 inverts the result. A failing condition loads `imm_flags_i` into `flags_o`. A passing condition loads the comparison result.
- R8: Condition codes 14 and 15 both always pass.
- R9: `flags_o` and `err_o` update on the rising clock edge where `req_vld_i` is 1. With `req_vld_i` at 0 they hold their values whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_vld_i | input | 1 | Request strobe; the inputs are consumed on this edge |
| opa_i | input | 64 | First operand |
| opb_i | input | 64 | Second operand |
| size_i | input | 2 | Precision code: 0 single, 1 double, others invalid |
| zero_cmp_i | input | 1 | Compare the first operand against +0.0 |
| cond_mode_i | input | 1 | Enable the conditional form |
| cond_code_i | input | 4 | Condition code tested in conditional mode |
| flags_in_i | input | 4 | Current flags that the condition is tested against |
| imm_flags_i | input | 4 | Flags loaded when the condition fails |
| flags_o | output | 4 | Registered N,Z,C,V result |
| err_o | output | 1 | Registered invalid-size indication |

## Verification
Every result, including the flags, the error bit and the immediate substitution, is due exactly one rising edge after the request. The bench drives each request on a falling edge and samples at the next falling edge, so exactly one register stage lies between stimulus and sample. The hold behaviour is checked the same way. The bench changes the inputs with the request strobe low and samples one falling edge later, which shows that nothing moved. The bound checker uses the same one-edge offset through `|=>` from the request cycle.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;

  localparam int unsigned SP_EXPW  = 8;
  localparam int unsigned SP_FRACW = 23;
  localparam int unsigned DP_EXPW  = 11;
  localparam int unsigned DP_FRACW = 52;
  localparam int unsigned SP_W     = 1 + SP_EXPW + SP_FRACW;
  localparam int unsigned DP_W     = 1 + DP_EXPW + DP_FRACW;
  localparam int unsigned MAG_W    = DP_W - 1;

  localparam int unsigned FLG_N = 3;
  localparam int unsigned FLG_Z = 2;
  localparam int unsigned FLG_C = 1;
  localparam int unsigned FLG_V = 0;

  localparam logic [1:0] SZ_SINGLE = 2'd0;
  localparam logic [1:0] SZ_DOUBLE = 2'd1;

  localparam logic [3:0] UNORD_FLAGS = 4'b0011;

  typedef struct packed {
    logic             sign;
    logic [MAG_W-1:0] mag;
    logic             nan;
    logic             zero;
  } fpval_t;

  typedef enum logic [2:0] {
    TST_Z   = 3'd0,
    TST_C   = 3'd1,
    TST_N   = 3'd2,
    TST_V   = 3'd3,
    TST_HI  = 3'd4,
    TST_GE  = 3'd5,
    TST_GT  = 3'd6,
    TST_ANY = 3'd7
  } cond_base_e;

  // Condition test on N,Z,C,V; low code bit inverts, except the all-ones code.
  function automatic logic cond_holds(input logic [3:0] code, input logic [3:0] f);
    logic base;
    case (cond_base_e'(code[3:1]))
      TST_Z:   base = f[FLG_Z];
      TST_C:   base = f[FLG_C];
      TST_N:   base = f[FLG_N];
      TST_V:   base = f[FLG_V];
      TST_HI:  base = f[FLG_C] & ~f[FLG_Z];
      TST_GE:  base = (f[FLG_N] == f[FLG_V]);
      TST_GT:  base = ~f[FLG_Z] & (f[FLG_N] == f[FLG_V]);
      default: base = 1'b1;
    endcase
    if (code[0] && (code != 4'hF)) return ~base;
    return base;
  endfunction

  // Strict less-than on unpacked values (neither NaN).
  function automatic logic val_less(input fpval_t a, input fpval_t b);
    if (a.zero && b.zero)  return 1'b0;
    if (a.sign != b.sign)  return a.sign;
    if (!a.sign)           return a.mag < b.mag;
    return a.mag > b.mag;
  endfunction

  function automatic logic val_equal(input fpval_t a, input fpval_t b);
    if (a.zero && b.zero) return 1'b1;
    return (a.sign == b.sign) && (a.mag == b.mag);
  endfunction

endpackage

// File: rtl/fpcmp_unpack.sv
module fpcmp_unpack
  import fpcmp_pkg::*;
#(
  parameter int unsigned OPW = 64
) (
  input  logic [OPW-1:0] op_i,
  input  logic           dbl_i,
  input  logic           force_zero_i,
  output fpval_t         val_o
);
  localparam int unsigned SP_FRAC_MSB = SP_FRACW - 1;
  localparam int unsigned DP_FRAC_MSB = DP_FRACW - 1;

  logic [SP_EXPW-1:0]  sp_exp;
  logic [SP_FRACW-1:0] sp_frac;
  logic [DP_EXPW-1:0]  dp_exp;
  logic [DP_FRACW-1:0] dp_frac;
  logic                sp_nan;
  logic                dp_nan;

  assign sp_exp  = op_i[SP_W-2 -: SP_EXPW];
  assign sp_frac = op_i[SP_FRAC_MSB:0];
  assign dp_exp  = op_i[DP_W-2 -: DP_EXPW];
  assign dp_frac = op_i[DP_FRAC_MSB:0];
  assign sp_nan  = (&sp_exp) & (|sp_frac);
  assign dp_nan  = (&dp_exp) & (|dp_frac);

  always_comb begin
    val_o = '0;
    if (force_zero_i) begin
      val_o.zero = 1'b1;
    end else if (dbl_i) begin
      val_o.sign = op_i[DP_W-1];
      val_o.mag  = op_i[DP_W-2:0];
      val_o.nan  = dp_nan;
      val_o.zero = (op_i[DP_W-2:0] == '0);
    end else begin
      val_o.sign = op_i[SP_W-1];
      val_o.mag  = MAG_W'(op_i[SP_W-2:0]);
      val_o.nan  = sp_nan;
      val_o.zero = (op_i[SP_W-2:0] == '0);
    end
  end

  logic unused_hi;
  assign unused_hi = ^op_i[OPW-1:DP_W-1] ^ op_i[SP_W-1];
endmodule

// File: rtl/fpcmp_order.sv
module fpcmp_order
  import fpcmp_pkg::*;
(
  input  fpval_t     a_i,
  input  fpval_t     b_i,
  output logic [3:0] flags_o,
  output logic       nan_o
);
  logic lt, eq;

  assign nan_o = a_i.nan | b_i.nan;
  assign lt    = val_less(a_i, b_i);
  assign eq    = val_equal(a_i, b_i);

  always_comb begin
    if (nan_o) begin
      flags_o = UNORD_FLAGS;
    end else begin
      flags_o        = '0;
      flags_o[FLG_N] = lt;
      flags_o[FLG_Z] = eq;
      flags_o[FLG_C] = ~lt;
      flags_o[FLG_V] = 1'b0;
    end
  end
endmodule

// File: rtl/fpcmp_cond.sv
module fpcmp_cond
  import fpcmp_pkg::*;
(
  input  logic       enable_i,
  input  logic [3:0] code_i,
  input  logic [3:0] flags_i,
  output logic       pass_o
);
  assign pass_o = ~enable_i | cond_holds(code_i, flags_i);
endmodule

// File: rtl/fpcmp_flag_unit.sv
module fpcmp_flag_unit
  import fpcmp_pkg::*;
#(
  parameter int unsigned OPW = 64
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           req_vld_i,
  input  logic [OPW-1:0] opa_i,
  input  logic [OPW-1:0] opb_i,
  input  logic [1:0]     size_i,
  input  logic           zero_cmp_i,
  input  logic           cond_mode_i,
  input  logic [3:0]     cond_code_i,
  input  logic [3:0]     flags_in_i,
  input  logic [3:0]     imm_flags_i,
  output logic [3:0]     flags_o,
  output logic           err_o
);
  localparam int unsigned NOPS = 2;

  logic [OPW-1:0] ops      [NOPS];
  fpval_t         vals     [NOPS];
  logic           dbl;
  logic           size_bad;
  logic           nan_hit;
  logic           cond_pass;
  logic           cmp_taken;
  logic [3:0]     cmp_flags;
  logic [3:0]     next_flags;
  logic [3:0]     flags_q;
  logic           err_q;

  assign ops[0]   = opa_i;
  assign ops[1]   = opb_i;
  assign dbl      = (size_i == SZ_DOUBLE);
  assign size_bad = (size_i != SZ_SINGLE) && (size_i != SZ_DOUBLE);

  for (genvar g = 0; g < NOPS; g++) begin : g_unpack
    fpcmp_unpack #(.OPW(OPW)) u_unpack (
      .op_i        (ops[g]),
      .dbl_i       (dbl),
      .force_zero_i((g == 1) ? zero_cmp_i : 1'b0),
      .val_o       (vals[g])
    );
  end

  fpcmp_order u_order (
    .a_i    (vals[0]),
    .b_i    (vals[1]),
    .flags_o(cmp_flags),
    .nan_o  (nan_hit)
  );

  fpcmp_cond u_cond (
    .enable_i(cond_mode_i),
    .code_i  (cond_code_i),
    .flags_i (flags_in_i),
    .pass_o  (cond_pass)
  );

  assign cmp_taken  = cond_pass;
  assign next_flags = cmp_taken ? cmp_flags : imm_flags_i;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      flags_q <= '0;
      err_q   <= 1'b0;
    end else if (req_vld_i) begin
      err_q <= size_bad;
      if (!size_bad) flags_q <= next_flags;
    end
  end

  assign flags_o = flags_q;
  assign err_o   = err_q;
endmodule

// File: rtl/fpcmp_flag_chk.sv
module fpcmp_flag_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_vld,
  input logic       cond_mode,
  input logic [3:0] cond_code,
  input logic [3:0] imm_flags,
  input logic [3:0] flags_o,
  input logic       err_o,
  input logic       size_bad,
  input logic       nan_hit,
  input logic       cmp_taken
);
  // R2
  bad_size_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && size_bad) |=> (err_o && $stable(flags_o)));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld |=> ($stable(flags_o) && $stable(err_o)));

  // R3
  unordered_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && !size_bad && cmp_taken && nan_hit) |=> (flags_o == 4'b0011));

  // R4
  ordered_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && !size_bad && cmp_taken && !nan_hit) |=>
      (!flags_o[0] && (flags_o[3] != flags_o[1]) && !err_o));

  // R7
  cond_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && !size_bad && !cmp_taken) |=> (flags_o == $past(imm_flags)));

  // R8
  always_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_mode && (cond_code[3:1] == 3'b111)) |-> cmp_taken);
endmodule

bind fpcmp_flag_unit fpcmp_flag_chk u_chk (
  .clk      (clk_i),
  .rst_n    (rst_ni),
  .req_vld  (req_vld_i),
  .cond_mode(cond_mode_i),
  .cond_code(cond_code_i),
  .imm_flags(imm_flags_i),
  .flags_o  (flags_o),
  .err_o    (err_o),
  .size_bad (size_bad),
  .nan_hit  (nan_hit),
  .cmp_taken(cmp_taken)
);

// File: tb/sim_fpcmp_flag_unit.sv
`timescale 1ns/1ps
module sim_fpcmp_flag_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_vld;
  logic [63:0] opa, opb;
  logic [1:0]  size;
  logic        zero_cmp, cond_mode;
  logic [3:0]  cond_code, flags_in, imm_flags;
  logic [3:0]  flags_o;
  logic        err_o;

  int checks = 0;
  int errors = 0;
  logic [3:0] model_flags = 4'b0000;
  logic       model_err = 1'b0;

  always #5 clk = ~clk;

  fpcmp_flag_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_vld_i(req_vld), .opa_i(opa), .opb_i(opb),
    .size_i(size), .zero_cmp_i(zero_cmp), .cond_mode_i(cond_mode),
    .cond_code_i(cond_code), .flags_in_i(flags_in), .imm_flags_i(imm_flags),
    .flags_o(flags_o), .err_o(err_o)
  );

  // Single precision: map to an unsigned key whose order matches numeric order.
  function automatic logic [31:0] sp_key(input logic [31:0] x);
    if (x[30:0] == 31'd0) return 32'h8000_0000;
    if (x[31]) return ~x;
    return x | 32'h8000_0000;
  endfunction

  function automatic logic sp_nan(input logic [31:0] x);
    return (x[30:23] == 8'hFF) && (x[22:0] != 0);
  endfunction

  function automatic logic dp_nan(input logic [63:0] x);
    return (x[62:52] == 11'h7FF) && (x[51:0] != 0);
  endfunction

  function automatic logic [3:0] ref_cmp(input logic [63:0] a, input logic [63:0] b,
                                         input logic dbl, input logic zc);
    logic [63:0] bb;
    logic lt, eq;
    bb = zc ? 64'd0 : b;
    if (dbl) begin
      if (dp_nan(a) || dp_nan(bb)) return 4'b0011;
      lt = $bitstoreal(a) < $bitstoreal(bb);
      eq = $bitstoreal(a) == $bitstoreal(bb);
    end else begin
      if (sp_nan(a[31:0]) || sp_nan(bb[31:0])) return 4'b0011;
      lt = sp_key(a[31:0]) < sp_key(bb[31:0]);
      eq = sp_key(a[31:0]) == sp_key(bb[31:0]);
    end
    return {lt, eq, !lt, 1'b0};
  endfunction

  function automatic logic ref_cond(input logic [3:0] c, input logic [3:0] f);
    logic n, z, cy, v;
    {n, z, cy, v} = f;
    case (c)
      4'd0:  return z;          4'd1:  return !z;
      4'd2:  return cy;         4'd3:  return !cy;
      4'd4:  return n;          4'd5:  return !n;
      4'd6:  return v;          4'd7:  return !v;
      4'd8:  return cy && !z;   4'd9:  return !(cy && !z);
      4'd10: return n == v;     4'd11: return n != v;
      4'd12: return !z && (n == v);
      4'd13: return z || (n != v);
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [63:0] pick_sp(input int sel);
    logic [63:0] r;
    r = {$urandom, $urandom};
    case (sel)
      0: r[31:0] = 32'h0000_0000;
      1: r[31:0] = 32'h8000_0000;
      2: r[31:0] = 32'h7F80_0000;
      3: r[31:0] = 32'hFF80_0000;
      4: r[31:0] = 32'h7FC0_0001;
      5: r[31:0] = 32'hFF80_0005;
      default: r[30:23] = 8'd125 + 8'($urandom_range(0, 3));
    endcase
    return r;
  endfunction

  function automatic logic [63:0] pick_dp(input int sel);
    logic [63:0] r;
    r = {$urandom, $urandom};
    case (sel)
      0: r = 64'h0;
      1: r = 64'h8000_0000_0000_0000;
      2: r = 64'h7FF0_0000_0000_0000;
      3: r = 64'hFFF0_0000_0000_0000;
      4: r = 64'h7FF8_0000_0000_0000;
      5: r = 64'hFFF0_0000_0000_0001;
      default: r[62:52] = 11'd1021 + 11'($urandom_range(0, 3));
    endcase
    return r;
  endfunction

  task automatic check(input string req, input logic [3:0] exp_f, input logic exp_e);
    checks++;
    if (flags_o !== exp_f || err_o !== exp_e) begin
      errors++;
      $display("FAIL %s flags=%b err=%b expected flags=%b err=%b", req, flags_o, err_o, exp_f, exp_e);
    end
  endtask

  // Drive on a falling edge, result registered at the rising edge, sample next falling edge.
  task automatic run(input string req, input logic [63:0] a, input logic [63:0] b,
                     input logic [1:0] sz, input logic zc, input logic cm,
                     input logic [3:0] cc, input logic [3:0] fin, input logic [3:0] imm);
    opa = a; opb = b; size = sz; zero_cmp = zc; cond_mode = cm;
    cond_code = cc; flags_in = fin; imm_flags = imm; req_vld = 1'b1;
    if (sz > 2'd1) begin
      model_err = 1'b1;
    end else begin
      model_err = 1'b0;
      if (cm && !ref_cond(cc, fin)) model_flags = imm;
      else model_flags = ref_cmp(a, b, sz == 2'd1, zc);
    end
    @(negedge clk);
    req_vld = 1'b0;
    check(req, model_flags, model_err);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_vld = 1'b0; opa = '0; opb = '0; size = '0;
    zero_cmp = 1'b0; cond_mode = 1'b0; cond_code = '0; flags_in = '0; imm_flags = '0;
    repeat (3) @(negedge clk);
    check("R1", 4'b0000, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 4'b0000, 1'b0);

    // Directed corner cases
    run("R5", 64'h0, 64'h8000_0000, 2'd0, 0, 0, 0, 0, 0);                     // +0 vs -0 single
    run("R5", 64'h8000_0000_0000_0000, 64'h0, 2'd1, 0, 0, 0, 0, 0);            // -0 vs +0 double
    run("R5", 64'h7FF0_0000_0000_0000, 64'h7FEF_FFFF_FFFF_FFFF, 2'd1, 0, 0, 0, 0, 0);
    run("R5", 64'hFF80_0000, 64'hFF7F_FFFF, 2'd0, 0, 0, 0, 0, 0);              // -inf < -max
    run("R4", 64'h3F80_0000, 64'h4000_0000, 2'd0, 0, 0, 0, 0, 0);              // 1 < 2
    run("R4", 64'hC000_0000, 64'hBF80_0000, 2'd0, 0, 0, 0, 0, 0);              // -2 < -1
    run("R2", 64'hDEAD_BEEF_3F80_0000, 64'h1234_5678_3F80_0000, 2'd0, 0, 0, 0, 0, 0);
    run("R3", 64'h7FC0_0000, 64'h3F80_0000, 2'd0, 0, 0, 0, 0, 0);
    run("R3", 64'h3FF0_0000_0000_0000, 64'h7FF0_0000_0000_0001, 2'd1, 0, 0, 0, 0, 0);
    run("R6", 64'hBF80_0000, 64'h7FC0_0000, 2'd0, 1, 0, 0, 0, 0);              // NaN b ignored
    run("R6", 64'h8000_0000_0000_0000, 64'h4000_0000_0000_0000, 2'd1, 1, 0, 0, 0, 0);
    run("R3", 64'h7FF8_0000_0000_0000, 64'h0, 2'd1, 1, 0, 0, 0, 0);
    run("R2", 64'h3F80_0000, 64'h0, 2'd2, 0, 0, 0, 0, 0);                      // invalid, hold
    run("R2", 64'h3F80_0000, 64'h0, 2'd3, 0, 1, 4'd0, 4'b0000, 4'b1111);
    run("R2", 64'h0, 64'h3F80_0000, 2'd0, 0, 0, 0, 0, 0);                      // clears err
    run("R7", 64'h0, 64'h0, 2'd0, 0, 1, 4'd0, 4'b0000, 4'b1010);                // EQ fails
    run("R7", 64'h0, 64'h3F80_0000, 2'd0, 0, 1, 4'd0, 4'b0100, 4'b1010);        // EQ passes
    run("R8", 64'h3F80_0000, 64'h0, 2'd0, 0, 1, 4'd14, 4'b0000, 4'b0001);
    run("R8", 64'h3F80_0000, 64'h0, 2'd0, 0, 1, 4'd15, 4'b1111, 4'b0001);

    // R9: inputs change without a request; state must hold
    opa = 64'h7FC0_0000; opb = 64'h0; size = 2'd3; imm_flags = 4'b1001; cond_mode = 1'b1;
    @(negedge clk);
    check("R9", model_flags, model_err);

    // Constrained random
    for (int i = 0; i < 3000; i++) begin
      logic dbl;
      logic [63:0] a, b;
      logic [1:0] sz;
      dbl = $urandom_range(0, 1);
      a = dbl ? pick_dp($urandom_range(0, 15)) : pick_sp($urandom_range(0, 15));
      case ($urandom_range(0, 3))
        0: b = a;
        1: begin b = a; b[dbl ? 63 : 31] = ~b[dbl ? 63 : 31]; end
        default: b = dbl ? pick_dp($urandom_range(0, 15)) : pick_sp($urandom_range(0, 15));
      endcase
      sz = ($urandom_range(0, 19) == 0) ? 2'($urandom_range(2, 3)) : {1'b0, dbl};
      run("R4 R7", a, b, sz, $urandom_range(0, 4) == 0, $urandom_range(0, 1),
          4'($urandom), 4'($urandom), 4'($urandom));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    $urandom(32'd20250611);
  end
endmodule